// File: doc/BRIEF.md
# Byte-Lane Controller for Asynchronous Static Memory

This block turns a clocked request port into the strobe sequences an asynchronous static memory needs. The memory is four 8-bit banks sharing a 17-bit address bus. Each bank has its own active-low chip select and active-low write strobe. One active-low output enable is shared by all banks, and the 32-bit data bus is tri-state. A request is taken with a valid/ready handshake. The controller then runs a fixed sequence: address setup, the strobe, a hold cycle for writes and a bus turnaround for reads. The length of each phase is a whole number of system clocks, set by a parameter.

A run-time width selector decides how the same banks are seen. In word mode they form a 32-bit memory, and the byte enables mask each lane's write strobe. In halfword mode the memory is twice as deep and 16 bits wide: the lowest request address bit picks the lower or upper lane pair. In byte mode it is four times as deep: the two lowest bits pick one lane. Write data is steered onto the chosen lanes. Read data comes back right-aligned and zero-extended, with a one-cycle response pulse. The tri-state bus appears as separate drive-value, drive-enable and sampled-input signals; the pad ring resolves them.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready is 1, every mem_cs_n and mem_we_n bit is 1, mem_oe_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: req_ready is 1 only while the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. After taking a request that selects at least one lane, req_ready is 0 in the following cycle, and no chip select is low while req_ready is 1.
- R3: With width_mode 2'b00 (word), mem_addr equals req_addr[16:0] and req_addr[18:17] have no effect. Lane i (i = 0..3) carries data bits 8i+7..8i and is selected when req_be[i] is 1.
- R4: With width_mode 2'b01 (halfword), mem_addr equals req_addr[17:1]. req_addr[0] = 0 selects lanes 0 and 1, and req_addr[0] = 1 selects lanes 2 and 3. req_be[0] enables the lower lane of the pair and req_be[1] the upper one. The lower lane of the pair carries req_wdata[7:0] and the upper lane carries req_wdata[15:8].
- R5: With width_mode 2'b10 or 2'b11 (byte), mem_addr equals req_addr[18:2], req_addr[1:0] selects the single lane, and req_be[0] enables it. The lane carries req_wdata[7:0].
- R6: Read data on rsp_rdata is right-aligned. In word mode, byte i comes from lane i. In halfword mode bits 15:0 hold the lower and upper lane of the pair. In byte mode bits 7:0 hold the selected lane. Every bit not filled from a selected lane reads 0.
- R7: A chip select goes low only for a lane the current request selects, a write strobe goes low only while that lane's chip select is low, and mem_oe_n is never low while any write strobe is low.
- R8: A write holds the chip selects low with data driven for one setup cycle. It then drives the selected write strobes low for exactly STROBE_CYC consecutive cycles and keeps data driven with strobes high for one hold cycle. mem_addr is stable throughout, and req_ready returns STROBE_CYC+3 cycles after the accepting edge.
- R9: A read holds mem_oe_n low for SAMPLE_CYC cycles after one setup cycle and samples the bus at the end of the last of them. rsp_valid is 1 for exactly one cycle, SAMPLE_CYC+2 cycles after the accepting edge.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0. After mem_oe_n rises, at least TURN_CYC cycles pass before mem_dq_oe is 1, so the controller never drives while the memory may still be driving.
- R11: A request that selects no lane drives no chip select or strobe. A write of that kind completes with req_ready back at 1 one cycle after acceptance. A read of that kind gives rsp_valid one cycle after acceptance with rsp_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address in units of the selected width |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data, right-aligned in narrow modes |
| width_mode | input | 2 | 00 word, 01 halfword, 1x byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 32 | Read data, right-aligned and zero-extended |
| mem_addr | output | 17 | Memory address bus |
| mem_cs_n | output | 4 | Per-lane chip selects, active low |
| mem_we_n | output | 4 | Per-lane write strobes, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |
| mem_dq_in | input | 32 | Value sampled from the data bus |

## Verification
The memory model only hands out valid data once output enable has been low for the sample delay; before that it returns a filler pattern. A read that samples early therefore shows up at once. The model also keeps the bus busy for the turnaround count after a read, so a write that drives too soon is flagged as contention.

Word-mode writes with full and partial byte enables, followed by full and masked reads, show whether the lanes merge and whether the unselected bytes are zeroed. Halfword and byte writes at every low-address value are read back in word mode, which shows whether each lane was steered and whether the address was shifted correctly. Requests with no enable show whether they bypass the strobes. A read followed at once by a write exercises the turnaround, and high address bits set in word mode show that those bits are ignored.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_TURN
   } seq_st_t;

   localparam logic [1:0] WM_WORD = 2'b00;
   localparam logic [1:0] WM_HALF = 2'b01;
endpackage

// File: rtl/sram_lane_map.sv
// Decodes a request into a physical address, a lane mask and steered write data.
module sram_lane_map
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W+1:0] addr,
   input  logic [LANES-1:0]  be,
   input  logic [DW-1:0]     wdata,
   output logic [ADDR_W-1:0] maddr,
   output logic [LANES-1:0]  lanes,
   output logic [DW-1:0]     lane_wdata
);
   always_comb begin
      case (mode)
         WM_WORD: maddr = addr[ADDR_W-1:0];
         WM_HALF: maddr = addr[ADDR_W:1];
         default: maddr = addr[ADDR_W+1:2];
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic pick_half;
      logic pick_byte;
      assign pick_half = (addr[0] == 1'(i / 2)) && be[i % 2];
      assign pick_byte = (addr[1:0] == 2'(i)) && be[0];
      assign lanes[i] = (mode == WM_WORD) ? be[i] :
                        (mode == WM_HALF) ? pick_half : pick_byte;
      assign lane_wdata[i*LANE_W +: LANE_W] =
         (mode == WM_WORD) ? wdata[i*LANE_W +: LANE_W] :
         (mode == WM_HALF) ? wdata[(i % 2)*LANE_W +: LANE_W] :
                             wdata[LANE_W-1:0];
   end
endmodule

// File: rtl/sram_lane_rdalign.sv
// Masks unselected lanes and right-aligns the read data for the width mode.
module sram_lane_rdalign
   import sram_lane_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W,
   localparam int HW    = DW / 2
) (
   input  logic [1:0]       mode,
   input  logic [1:0]       lsel,
   input  logic [LANES-1:0] lanes,
   input  logic [DW-1:0]    dq_in,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] masked;

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign masked[i*LANE_W +: LANE_W] =
         lanes[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
   end

   always_comb begin
      rdata = '0;
      case (mode)
         WM_WORD: rdata = masked;
         WM_HALF: rdata[HW-1:0] = lsel[0] ? masked[DW-1:HW] : masked[HW-1:0];
         default: begin
            for (int k = 0; k < LANES; k++) begin
               if (lsel == 2'(k)) rdata[LANE_W-1:0] = masked[k*LANE_W +: LANE_W];
            end
         end
      endcase
   end
endmodule

// File: rtl/sram_lane_seq.sv
// Phase sequencer: idle, setup, strobe, hold (write) or turnaround (read).
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int STROBE_CYC = 2,
   parameter int SAMPLE_CYC = 2,
   parameter int TURN_CYC   = 2,
   localparam int MAXC = (STROBE_CYC > SAMPLE_CYC) ?
                         ((STROBE_CYC > TURN_CYC) ? STROBE_CYC : TURN_CYC) :
                         ((SAMPLE_CYC > TURN_CYC) ? SAMPLE_CYC : TURN_CYC),
   localparam int CW   = $clog2(MAXC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [LANES-1:0] lanes_next,
   input  logic [LANES-1:0] lanes_q,
   output logic             accept,
   output logic             cap,
   output logic             zcap,
   output logic             rsp_valid,
   output logic             ready,
   output logic [LANES-1:0] cs_n,
   output logic [LANES-1:0] we_n,
   output logic             oe_n,
   output logic             dq_oe
);
   seq_st_t       st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          wr_q;
   logic          busy;
   logic          empty;

   assign empty  = (lanes_next == '0);
   assign accept = (st == ST_IDLE) && req_valid;
   assign last   = wr_q ? CW'(STROBE_CYC - 1) : CW'(SAMPLE_CYC - 1);
   assign cap    = (st == ST_STROBE) && !wr_q && (cnt == last);
   assign zcap   = accept && empty && !req_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         wr_q      <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q <= req_write;
                  cnt  <= '0;
                  if (!empty) begin
                     st <= ST_SETUP;
                  end else if (!req_write) begin
                     st        <= ST_TURN;
                     rsp_valid <= 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               st  <= ST_STROBE;
               cnt <= '0;
            end
            ST_STROBE: begin
               if (cnt == last) begin
                  cnt <= '0;
                  if (wr_q) begin
                     st <= ST_HOLD;
                  end else begin
                     st        <= ST_TURN;
                     rsp_valid <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HOLD: st <= ST_IDLE;
            ST_TURN: begin
               if (cnt == CW'(TURN_CYC - 1)) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
   assign ready = (st == ST_IDLE);
   assign cs_n  = busy ? ~lanes_q : '1;
   assign we_n  = ((st == ST_STROBE) && wr_q) ? ~lanes_q : '1;
   assign oe_n  = !((st == ST_STROBE) && !wr_q);
   assign dq_oe = busy && wr_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
   parameter int ADDR_W     = 17,
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter int STROBE_CYC = 2,
   parameter int SAMPLE_CYC = 2,
   parameter int TURN_CYC   = 2,
   localparam int DW        = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W+1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   input  logic [DW-1:0]     req_wdata,
   input  logic [1:0]        width_mode,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_cs_n,
   output logic [LANES-1:0]  mem_we_n,
   output logic              mem_oe_n,
   output logic [DW-1:0]     mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DW-1:0]     mem_dq_in
);
   if (LANES != 4) begin : g_bad_lanes
      $error("sram_lane_ctrl: width steering needs exactly four lanes");
   end
   if (STROBE_CYC < 1 || SAMPLE_CYC < 1 || TURN_CYC < 1) begin : g_bad_timing
      $error("sram_lane_ctrl: every phase count must be at least one clock");
   end
   if (ADDR_W < 2 || LANE_W < 1) begin : g_bad_width
      $error("sram_lane_ctrl: address or lane width too small");
   end

   logic [ADDR_W-1:0] maddr_next;
   logic [LANES-1:0]  lanes_next;
   logic [DW-1:0]     wdata_next;
   logic [ADDR_W-1:0] maddr_q;
   logic [LANES-1:0]  lanes_q;
   logic [DW-1:0]     wdata_q;
   logic [1:0]        mode_q;
   logic [1:0]        lsel_q;
   logic [DW-1:0]     aligned;
   logic [DW-1:0]     rdata_q;
   logic              accept;
   logic              cap;
   logic              zcap;

   sram_lane_map #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_map (
      .mode       (width_mode),
      .addr       (req_addr),
      .be         (req_be),
      .wdata      (req_wdata),
      .maddr      (maddr_next),
      .lanes      (lanes_next),
      .lane_wdata (wdata_next)
   );

   sram_lane_seq #(
      .LANES(LANES), .STROBE_CYC(STROBE_CYC),
      .SAMPLE_CYC(SAMPLE_CYC), .TURN_CYC(TURN_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .lanes_next (lanes_next),
      .lanes_q    (lanes_q),
      .accept     (accept),
      .cap        (cap),
      .zcap       (zcap),
      .rsp_valid  (rsp_valid),
      .ready      (req_ready),
      .cs_n       (mem_cs_n),
      .we_n       (mem_we_n),
      .oe_n       (mem_oe_n),
      .dq_oe      (mem_dq_oe)
   );

   sram_lane_rdalign #(.LANES(LANES), .LANE_W(LANE_W)) u_align (
      .mode  (mode_q),
      .lsel  (lsel_q),
      .lanes (lanes_q),
      .dq_in (mem_dq_in),
      .rdata (aligned)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         maddr_q <= '0;
         lanes_q <= '0;
         wdata_q <= '0;
         mode_q  <= '0;
         lsel_q  <= '0;
      end else if (accept) begin
         maddr_q <= maddr_next;
         lanes_q <= lanes_next;
         wdata_q <= wdata_next;
         mode_q  <= width_mode;
         lsel_q  <= req_addr[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (cap)  rdata_q <= aligned;
      else if (zcap) rdata_q <= '0;
   end

   assign mem_addr   = maddr_q;
   assign mem_dq_out = wdata_q;
   assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W     = 17,
   parameter int LANES      = 4,
   parameter int STROBE_CYC = 2,
   parameter int TURN_CYC   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LANES-1:0]  mem_cs_n,
   input logic [LANES-1:0]  mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);
   int we_run;
   int gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run <= 0;
         gap    <= TURN_CYC;
      end else begin
         we_run <= (&mem_we_n) ? 0 : we_run + 1;
         if (!mem_oe_n)          gap <= 0;
         else if (gap < TURN_CYC) gap <= gap + 1;
      end
   end

   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_cs_n));

   assert_we_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_we_n) & mem_cs_n) == '0);

   assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (&mem_we_n));

   assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((&mem_we_n) && (we_run != 0)) |-> (we_run == STROBE_CYC));

   assert_data_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_we_n) |-> mem_dq_oe);

   assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> $stable(mem_addr));

   assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_no_drive_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (gap >= TURN_CYC));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W(ADDR_W), .LANES(LANES), .STROBE_CYC(STROBE_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int STROBE_CYC = 3;
   localparam int SAMPLE_CYC = 2;
   localparam int TURN_CYC   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  width_mode = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic [3:0]  mem_cs_n;
   logic [3:0]  mem_we_n;
   logic        mem_oe_n;
   logic [31:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [31:0] mem_dq_in = '0;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int we_pulses = 0;
   logic [3:0]  exp_lanes = '0;
   logic [16:0] exp_maddr = '0;
   string       addr_tag = "R3";

   logic [7:0] store  [int];
   logic [7:0] shadow [int];
   int we_len [4];
   int oe_lo = 0;
   int rel = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl #(
      .STROBE_CYC(STROBE_CYC), .SAMPLE_CYC(SAMPLE_CYC), .TURN_CYC(TURN_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .width_mode(width_mode), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] peek(input logic [7:0] arr [int], input int k);
      return arr.exists(k) ? arr[k] : 8'h00;
   endfunction

   // Behavioural memory: truth-table decode, write capture, access delay,
   // release delay and strobe-width check; contention check every clock.
   always @(negedge clk) begin
      logic drive;
      cycles++;
      if (rst_n) begin
         drive = 1'b0;
         if (!mem_oe_n) oe_lo++; else oe_lo = 0;
         for (int i = 0; i < 4; i++) begin
            if (!mem_cs_n[i] && mem_we_n[i] && !mem_oe_n) drive = 1'b1;
            if (!mem_cs_n[i] && !mem_we_n[i]) begin
               store[int'(mem_addr)*4 + i] = mem_dq_out[i*8 +: 8];
               we_len[i]++;
            end else if (we_len[i] != 0) begin
               chk(we_len[i] == STROBE_CYC, "R8", we_len[i], STROBE_CYC);
               we_len[i] = 0;
               we_pulses++;
            end
            if (!mem_cs_n[i] && mem_we_n[i] && !mem_oe_n)
               mem_dq_in[i*8 +: 8] = (oe_lo >= SAMPLE_CYC) ?
                  peek(store, int'(mem_addr)*4 + i) : 8'hA5;
            else
               mem_dq_in[i*8 +: 8] = 8'h00;
         end
         if (mem_dq_oe) chk(!(drive || rel > 0), "R10", {31'd0, drive}, 32'd0);
         rel = drive ? TURN_CYC : (rel > 0 ? rel - 1 : 0);
         if ((~mem_cs_n & ~exp_lanes) != 4'd0)
            chk(1'b0, "R7", {28'd0, ~mem_cs_n}, {28'd0, exp_lanes});
         if (mem_cs_n != 4'hF)
            chk(mem_addr == exp_maddr, addr_tag, {15'd0, mem_addr}, {15'd0, exp_maddr});
      end
   end

   function automatic logic [3:0] calc_lanes(input logic [1:0] md,
                                             input logic [18:0] a,
                                             input logic [3:0] be);
      if (md == 2'b00) return be;
      if (md == 2'b01) return a[0] ? {be[1:0], 2'b00} : {2'b00, be[1:0]};
      return be[0] ? (4'd1 << a[1:0]) : 4'd0;
   endfunction

   function automatic logic [16:0] calc_maddr(input logic [1:0] md,
                                              input logic [18:0] a);
      if (md == 2'b00) return a[16:0];
      if (md == 2'b01) return a[17:1];
      return a[18:2];
   endfunction

   function automatic int pos(input logic [1:0] md, input int i);
      if (md == 2'b00) return i;
      if (md == 2'b01) return i % 2;
      return 0;
   endfunction

   task automatic access(input bit wr, input logic [1:0] md, input logic [18:0] a,
                         input logic [31:0] wd, input logic [3:0] be,
                         input string dtag, output logic [31:0] rd);
      logic [3:0]  ln;
      logic [16:0] ma;
      logic [31:0] exp;
      int n;
      int p0;
      int expn;
      ln = calc_lanes(md, a, be);
      ma = calc_maddr(md, a);
      rd = '0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      exp_lanes = ln;
      exp_maddr = ma;
      addr_tag  = (md == 2'b00) ? "R3" : (md == 2'b01) ? "R4" : "R5";
      req_valid = 1'b1; req_write = wr; width_mode = md;
      req_addr = a; req_wdata = wd; req_be = be;
      p0 = we_pulses;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      if (ln != 4'd0) chk(req_ready == 1'b0, "R2", {31'd0, req_ready}, 32'd0);
      if (wr) begin
         while (!req_ready && n < 64) begin @(negedge clk); n++; end
         expn = (ln == 4'd0) ? 1 : STROBE_CYC + 3;
         chk(n == expn, (ln == 4'd0) ? "R11" : "R8", n, expn);
         chk(we_pulses - p0 == $countones(ln), (ln == 4'd0) ? "R11" : dtag,
             we_pulses - p0, $countones(ln));
         for (int i = 0; i < 4; i++)
            if (ln[i]) shadow[int'(ma)*4 + i] = wd[pos(md, i)*8 +: 8];
      end else begin
         while (!rsp_valid && n < 64) begin @(negedge clk); n++; end
         expn = (ln == 4'd0) ? 1 : SAMPLE_CYC + 2;
         chk(n == expn, (ln == 4'd0) ? "R11" : "R9", n, expn);
         rd  = rsp_rdata;
         exp = '0;
         for (int i = 0; i < 4; i++)
            if (ln[i]) exp[pos(md, i)*8 +: 8] = peek(shadow, int'(ma)*4 + i);
         chk(rd == exp, (ln == 4'd0) ? "R11" : dtag, rd, exp);
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
         while (!req_ready) @(negedge clk);
      end
      exp_lanes = 4'd0;
   endtask

   initial begin
      while (cycles < 100000) @(negedge clk);
      chk(1'b0, "watchdog", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 4; i++) we_len[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", {31'd0, req_ready}, 32'd1);
      chk(mem_cs_n == 4'hF && mem_we_n == 4'hF, "R1", {24'd0, mem_cs_n, mem_we_n}, 32'hFF);
      chk(mem_oe_n == 1'b1 && mem_dq_oe == 1'b0 && rsp_valid == 1'b0, "R1",
          {29'd0, mem_oe_n, mem_dq_oe, rsp_valid}, 32'h4);

      // R3 / R6 word mode, full and partial enables
      access(1, 2'b00, 19'h00010, 32'hDEADBEEF, 4'hF, "R3", r);
      access(0, 2'b00, 19'h00010, 32'h0, 4'hF, "R6", r);
      access(1, 2'b00, 19'h00010, 32'h11223344, 4'b0101, "R3", r);
      access(0, 2'b00, 19'h00010, 32'h0, 4'hF, "R3", r);
      chk(r == 32'hDE22BE44, "R3", r, 32'hDE22BE44);
      access(0, 2'b00, 19'h00010, 32'h0, 4'b0011, "R6", r);
      // R3 high address bits ignored in word mode
      access(0, 2'b00, 19'h60010, 32'h0, 4'hF, "R3", r);
      chk(r == 32'hDE22BE44, "R3", r, 32'hDE22BE44);

      // R4 halfword mode, both pairs, then word readback of placement
      access(1, 2'b01, 19'h00041, 32'hFFFFA1B2, 4'b0011, "R4", r);
      access(1, 2'b01, 19'h00040, 32'h0000C3D4, 4'b0011, "R4", r);
      access(1, 2'b01, 19'h00040, 32'h00009900, 4'b0010, "R4", r);
      access(0, 2'b00, 19'h00020, 32'h0, 4'hF, "R4", r);
      chk(r == 32'hA1B299D4, "R4", r, 32'hA1B299D4);
      access(0, 2'b01, 19'h00041, 32'h0, 4'b0011, "R6", r);
      chk(r == 32'h0000A1B2, "R6", r, 32'h0000A1B2);

      // R5 byte mode, every lane, mode 11 too
      for (int k = 0; k < 4; k++)
         access(1, (k % 2 == 0) ? 2'b10 : 2'b11, 19'h00200 + 19'(k),
                32'hFFFFFF50 + 32'(k), 4'h1, "R5", r);
      access(0, 2'b00, 19'h00080, 32'h0, 4'hF, "R5", r);
      chk(r == 32'h53525150, "R5", r, 32'h53525150);
      access(0, 2'b11, 19'h00202, 32'h0, 4'h1, "R6", r);
      chk(r == 32'h00000052, "R6", r, 32'h00000052);

      // R11 requests with no lane
      access(1, 2'b00, 19'h00010, 32'h0BADF00D, 4'h0, "R11", r);
      access(1, 2'b10, 19'h00201, 32'h000000EE, 4'hE, "R11", r);
      access(0, 2'b00, 19'h00010, 32'h0, 4'h0, "R11", r);
      access(0, 2'b00, 19'h00010, 32'h0, 4'hF, "R11", r);
      chk(r == 32'hDE22BE44, "R11", r, 32'hDE22BE44);

      // R10 read followed at once by write
      access(0, 2'b00, 19'h00020, 32'h0, 4'hF, "R10", r);
      access(1, 2'b00, 19'h00021, 32'hCAFEF00D, 4'hF, "R10", r);
      access(0, 2'b00, 19'h00021, 32'h0, 4'hF, "R10", r);
      access(1, 2'b01, 19'h00042, 32'h00001234, 4'h3, "R10", r);
      access(0, 2'b00, 19'h00021, 32'h0, 4'hF, "R10", r);
      chk(r == 32'hCAFE1234, "R10", r, 32'hCAFE1234);

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule